// File: doc/BRIEF.md
# PTP Receive Timestamp Frame Classifier

This block watches the bytes of each received Ethernet frame as they stream past and decides, once per frame, whether the receive path should capture a timestamp for it. It recognises precision time protocol messages carried straight over Ethernet and carried in IPv4/UDP datagrams. It then compares the message version and message type with a small control word that software programs. The control word holds an enable bit, a mode, a UDP port selection and two programmable message types for each protocol version.

Bytes arrive one per cycle on a valid/last stream. Byte 0 is the first destination MAC byte, and multi-byte fields are big-endian. The block assumes no VLAN tag and a fixed 20-byte IPv4 header. When the last byte of a frame is accepted, the block registers a decision and presents it one cycle later as a single-cycle pulse with a sample flag. The receive path combines that flag with its own timestamp capture.

Top module: `rxts_classifier`

## Requirements
- R1: Each beat with in_valid and in_last high is followed, exactly one cycle later, by a single-cycle dec_valid pulse. dec_valid is never high otherwise, dec_sample is never high without dec_valid, and both are low after reset.
- R2: While the enable bit (control bit 0) is clear, every decision has dec_sample low.
- R3: The control word is enable in bit 0, mode in bits 2:1, port select in bits 4:3, v1 type A in 12:5, v1 type B in 20:13, v2 type A in 24:21 and v2 type B in 28:25. cfg_ctl_we loads bits 4:0 and cfg_type_we loads bits 28:5. At reset both B types are 1 and every other field is 0.
- R4: A frame with Ethertype 0x88F7 (bytes 12-13) carries the PTP header from byte 14. Such a frame is rejected in mode 1.
- R5: A frame with Ethertype 0x0800 and IP protocol 17 (byte 23) qualifies only when the mode is nonzero and the destination port (bytes 36-37) passes the port select. Port 0x013F needs port select bit 0, and port 0x0140 needs port select bit 1. Its PTP header starts at byte 42.
- R6: A header whose first two bytes are 0x00, 0x01 is version 1, with its type at header byte 20. It is sampled only in mode 1, and only if the type equals v1 type A or v1 type B, or if either of those is 0xFF.
- R7: A header whose byte 1 is 0x02 is version 2, with its type in byte 0. It is rejected in mode 1, and in mode 0 when it arrived over UDP.
- R8: In mode 3 a version 2 header is sampled exactly when its type byte is below 8.
- R9: In modes 0 and 2 a version 2 header is sampled when v2 type A is 0xF, or when its type byte equals v2 type A or v2 type B.
- R10: Frames with another Ethertype, IPv4 frames with another protocol, headers with another version, and frames that end before the bytes a check needs are not sampled. A frame ending on its last needed byte is decided on that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctl_we | input | 1 | Load enable, mode and port select from cfg_wdata |
| cfg_type_we | input | 1 | Load the four message types from cfg_wdata |
| cfg_wdata | input | 29 | Control word write data |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| dec_valid | output | 1 | Decision pulse, one per frame |
| dec_sample | output | 1 | Timestamp should be captured |

## Verification
Frames are built in four transports: Ethernet PTP, UDP to each of the two ports, IPv4 with a non-UDP protocol, and an unrelated Ethertype. Each carries a version 1, version 2 or unknown header. Sweeping the mode and port select over the same frames separates transport gating from version gating. Types that match A only, B only, neither, or a wildcard separate the two comparators from the wildcard paths. Frames cut one byte before and exactly at their last needed byte test the length tracking, and a frame with idle gaps and back-to-back frames shows that stalls and frame boundaries keep the byte count right.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

  localparam int CFG_W = 29;

  typedef struct packed {
    logic [3:0] v2_b;
    logic [3:0] v2_a;
    logic [7:0] v1_b;
    logic [7:0] v1_a;
    logic [1:0] port_sel;
    logic [1:0] mode;
    logic       enable;
  } rxts_cfg_t;

  typedef struct packed {
    logic [15:0] etype;
    logic [7:0]  proto;
    logic [15:0] dport;
    logic [7:0]  pb0;
    logic [7:0]  pb1;
    logic [7:0]  pb20;
  } rxts_hdr_t;

  localparam rxts_cfg_t CFG_RST = '{v2_b: 4'h1, v2_a: 4'h0, v1_b: 8'h01,
                                    v1_a: 8'h00, port_sel: 2'b00,
                                    mode: 2'b00, enable: 1'b0};

  localparam logic [15:0] ETH_PTP     = 16'h88F7;
  localparam logic [15:0] ETH_IP4     = 16'h0800;
  localparam logic [7:0]  IPP_UDP     = 8'd17;
  localparam logic [15:0] PORT_EVENT  = 16'h013F;
  localparam logic [15:0] PORT_GENRL  = 16'h0140;

  localparam int OFF_ETYPE  = 12;
  localparam int ETH_HDR    = 14;
  localparam int V1_TYPE_AT = 20;
  localparam int UDP_HDR    = 8;

endpackage

// File: rtl/rxts_ctl_regs.sv
module rxts_ctl_regs
  import rxts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             type_we,
  input  logic [CFG_W-1:0] wdata,
  output rxts_cfg_t        cfg_q
);

  rxts_cfg_t wr_word;
  rxts_cfg_t cfg_d;
  logic      cfg_en;

  assign wr_word = rxts_cfg_t'(wdata);
  assign cfg_en  = ctl_we | type_we;

  always_comb begin
    cfg_d = cfg_q;
    if (ctl_we) begin
      cfg_d.enable   = wr_word.enable;
      cfg_d.mode     = wr_word.mode;
      cfg_d.port_sel = wr_word.port_sel;
    end
    if (type_we) begin
      cfg_d.v1_a = wr_word.v1_a;
      cfg_d.v1_b = wr_word.v1_b;
      cfg_d.v2_a = wr_word.v2_a;
      cfg_d.v2_b = wr_word.v2_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_en) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/rxts_hdr_capture.sv
module rxts_hdr_capture
  import rxts_pkg::*;
#(
  parameter int LEN_W        = 7,
  parameter int IP_HDR_BYTES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output rxts_hdr_t        hdr_n,
  output logic [LEN_W-1:0] len_n,
  output logic [LEN_W-1:0] cnt_q
);

  localparam int OFF_PROTO = ETH_HDR + 9;
  localparam int OFF_DPORT = ETH_HDR + IP_HDR_BYTES + 2;
  localparam int OFF_UPTP  = ETH_HDR + IP_HDR_BYTES + UDP_HDR;

  localparam logic [LEN_W-1:0] LEN_MAX  = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] C_ET_HI  = LEN_W'(OFF_ETYPE);
  localparam logic [LEN_W-1:0] C_ET_LO  = LEN_W'(OFF_ETYPE + 1);
  localparam logic [LEN_W-1:0] C_PROTO  = LEN_W'(OFF_PROTO);
  localparam logic [LEN_W-1:0] C_DP_HI  = LEN_W'(OFF_DPORT);
  localparam logic [LEN_W-1:0] C_DP_LO  = LEN_W'(OFF_DPORT + 1);
  localparam logic [LEN_W-1:0] C_B_L2   = LEN_W'(ETH_HDR);
  localparam logic [LEN_W-1:0] C_B_UDP  = LEN_W'(OFF_UPTP);

  rxts_hdr_t        hdr_q;
  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] cnt_d;

  assign base  = (hdr_q.etype == ETH_IP4) ? C_B_UDP : C_B_L2;
  assign len_n = (cnt_q == LEN_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    hdr_n = hdr_q;
    if (in_valid) begin
      if (cnt_q == C_ET_HI)                      hdr_n.etype[15:8] = in_data;
      if (cnt_q == C_ET_LO)                      hdr_n.etype[7:0]  = in_data;
      if (cnt_q == C_PROTO)                      hdr_n.proto       = in_data;
      if (cnt_q == C_DP_HI)                      hdr_n.dport[15:8] = in_data;
      if (cnt_q == C_DP_LO)                      hdr_n.dport[7:0]  = in_data;
      if (cnt_q == base)                         hdr_n.pb0         = in_data;
      if (cnt_q == base + LEN_W'(1))             hdr_n.pb1         = in_data;
      if (cnt_q == base + LEN_W'(V1_TYPE_AT))    hdr_n.pb20        = in_data;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) cnt_d = in_last ? '0 : len_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      cnt_q <= '0;
    end else if (in_valid) begin
      hdr_q <= hdr_n;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rxts_match.sv
module rxts_match
  import rxts_pkg::*;
#(
  parameter int LEN_W        = 7,
  parameter int IP_HDR_BYTES = 20
) (
  input  rxts_cfg_t        cfg,
  input  rxts_hdr_t        hdr,
  input  logic [LEN_W-1:0] len,
  output logic             sample
);

  localparam int UPTP = ETH_HDR + IP_HDR_BYTES + UDP_HDR;

  localparam logic [LEN_W-1:0] N_ETH    = LEN_W'(ETH_HDR);
  localparam logic [LEN_W-1:0] N_UDPHDR = LEN_W'(ETH_HDR + IP_HDR_BYTES + 4);
  localparam logic [LEN_W-1:0] N_L2_VER = LEN_W'(ETH_HDR + 2);
  localparam logic [LEN_W-1:0] N_L2_V1T = LEN_W'(ETH_HDR + V1_TYPE_AT + 1);
  localparam logic [LEN_W-1:0] N_U_VER  = LEN_W'(UPTP + 2);
  localparam logic [LEN_W-1:0] N_U_V1T  = LEN_W'(UPTP + V1_TYPE_AT + 1);

  logic port_ok;
  logic hdr_ok;
  logic udp;
  logic is_v1;
  logic is_v2;
  logic v1_hit;
  logic v2_hit;
  logic [LEN_W-1:0] need_ver;
  logic [LEN_W-1:0] need_v1t;

  assign port_ok = (hdr.dport == PORT_EVENT && cfg.port_sel[0]) ||
                   (hdr.dport == PORT_GENRL && cfg.port_sel[1]);

  always_comb begin
    hdr_ok = 1'b0;
    udp    = 1'b0;
    if (cfg.enable && len >= N_ETH) begin
      if (hdr.etype == ETH_IP4) begin
        if (len >= N_UDPHDR && hdr.proto == IPP_UDP && cfg.mode != 2'd0 && port_ok) begin
          udp    = 1'b1;
          hdr_ok = 1'b1;
        end
      end else if (hdr.etype == ETH_PTP) begin
        hdr_ok = (cfg.mode != 2'd1);
      end
    end
  end

  assign need_ver = udp ? N_U_VER : N_L2_VER;
  assign need_v1t = udp ? N_U_V1T : N_L2_V1T;
  assign is_v1    = ({hdr.pb0, hdr.pb1} == 16'h0001);
  assign is_v2    = (hdr.pb1 == 8'h02);

  assign v1_hit = (cfg.v1_a == 8'hFF) || (cfg.v1_b == 8'hFF) ||
                  (hdr.pb20 == cfg.v1_a) || (hdr.pb20 == cfg.v1_b);

  always_comb begin
    if (cfg.mode == 2'd3)
      v2_hit = (hdr.pb0 < 8'd8);
    else
      v2_hit = (cfg.v2_a == 4'hF) || (hdr.pb0 == {4'h0, cfg.v2_a}) ||
               (hdr.pb0 == {4'h0, cfg.v2_b});
  end

  always_comb begin
    sample = 1'b0;
    if (hdr_ok && len >= need_ver) begin
      if (is_v1) begin
        sample = (cfg.mode == 2'd1) && (len >= need_v1t) && v1_hit;
      end else if (is_v2) begin
        sample = !(cfg.mode == 2'd1) && !(cfg.mode == 2'd0 && udp) && v2_hit;
      end
    end
  end

endmodule

// File: rtl/rxts_classifier.sv
module rxts_classifier
  import rxts_pkg::*;
#(
  parameter int LEN_W        = 7,
  parameter int IP_HDR_BYTES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ctl_we,
  input  logic             cfg_type_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             dec_valid,
  output logic             dec_sample
);

  rxts_cfg_t        cfg_q;
  rxts_hdr_t        hdr_n;
  logic [LEN_W-1:0] len_n;
  logic [LEN_W-1:0] cnt_q;
  logic             match;
  logic             dv_d;
  logic             ds_d;

  rxts_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (cfg_ctl_we),
    .type_we (cfg_type_we),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_q)
  );

  rxts_hdr_capture #(.LEN_W(LEN_W), .IP_HDR_BYTES(IP_HDR_BYTES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .hdr_n    (hdr_n),
    .len_n    (len_n),
    .cnt_q    (cnt_q)
  );

  rxts_match #(.LEN_W(LEN_W), .IP_HDR_BYTES(IP_HDR_BYTES)) u_match (
    .cfg    (cfg_q),
    .hdr    (hdr_n),
    .len    (len_n),
    .sample (match)
  );

  assign dv_d = in_valid & in_last;
  assign ds_d = dv_d & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_sample <= 1'b0;
    end else begin
      dec_valid  <= dv_d;
      dec_sample <= ds_d;
    end
  end

endmodule

// File: rtl/rxts_classifier_chk.sv
module rxts_classifier_chk
  import rxts_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             dec_valid,
  input logic             dec_sample,
  input rxts_cfg_t        cfg_q,
  input logic [LEN_W-1:0] cnt_q
);

  localparam logic [LEN_W-1:0] SHORT_CNT = LEN_W'(ETH_HDR - 1);

  AST_DEC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_last)); // R1

  AST_LAST_GIVES_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> dec_valid); // R1

  AST_SAMPLE_IN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sample |-> dec_valid); // R1

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !cfg_q.enable) |=> !dec_sample); // R2

  AST_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && cnt_q < SHORT_CNT) |=> !dec_sample); // R10

endmodule

bind rxts_classifier rxts_classifier_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .dec_valid  (dec_valid),
  .dec_sample (dec_sample),
  .cfg_q      (cfg_q),
  .cnt_q      (cnt_q)
);

// File: tb/rxts_classifier_test.sv
`timescale 1ns/1ps
module rxts_classifier_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ctl_we = 1'b0;
  logic        cfg_type_we = 1'b0;
  logic [28:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        dec_valid;
  logic        dec_sample;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  logic [7:0] fb [0:95];
  int flen;

  always #2 clk = ~clk;

  rxts_classifier uut (
    .clk(clk), .rst_n(rst_n), .cfg_ctl_we(cfg_ctl_we), .cfg_type_we(cfg_type_we),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .dec_valid(dec_valid), .dec_sample(dec_sample)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected decision", 1, 0);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dec_sample == e, t, int'(dec_sample), int'(e));
        end
      end else if (dec_sample) begin
        check(1'b0, "R1 sample without decision", 1, 0);
      end
    end
  end

  // kind: 0 ethernet PTP, 1 IPv4/UDP, 2 IPv4/TCP, 3 other ethertype
  // ver: 1, 2, or 3 for an unknown version
  task automatic build(input int kind, input logic [15:0] port, input int ver,
                       input logic [7:0] typ);
    int b;
    for (int i = 0; i < 96; i++) fb[i] = 8'(8'hA0 + i[3:0]);
    b = (kind == 0 || kind == 3) ? 14 : 42;
    case (kind)
      0: begin fb[12] = 8'h88; fb[13] = 8'hF7; end
      3: begin fb[12] = 8'h86; fb[13] = 8'hDD; end
      default: begin
        fb[12] = 8'h08; fb[13] = 8'h00;
        fb[23] = (kind == 1) ? 8'd17 : 8'd6;
        fb[36] = port[15:8]; fb[37] = port[7:0];
      end
    endcase
    if (ver == 1) begin
      fb[b] = 8'h00; fb[b+1] = 8'h01; fb[b+20] = typ;
    end else if (ver == 2) begin
      fb[b] = typ; fb[b+1] = 8'h02;
    end else begin
      fb[b] = typ; fb[b+1] = 8'h03;
    end
    flen = b + 44;
  endtask

  task automatic send(input int n, input bit exp, input string tag, input bit gaps);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fb[i];
      in_last  = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic frame(input int kind, input logic [15:0] port, input int ver,
                       input logic [7:0] typ, input bit exp, input string tag);
    build(kind, port, ver, typ);
    send(flen, exp, tag, 1'b0);
  endtask

  task automatic wr_ctl(input bit en, input logic [1:0] mode, input logic [1:0] ps);
    @(negedge clk);
    cfg_wdata   = {24'h0, ps, mode, en};
    cfg_ctl_we  = 1'b1;
    @(negedge clk);
    cfg_ctl_we  = 1'b0;
  endtask

  task automatic wr_types(input logic [7:0] v1a, input logic [7:0] v1b,
                          input logic [3:0] v2a, input logic [3:0] v2b);
    @(negedge clk);
    cfg_wdata   = {v2b, v2a, v1b, v1a, 5'h1F};
    cfg_type_we = 1'b1;
    @(negedge clk);
    cfg_type_we = 1'b0;
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [15:0] EV = 16'h013F;
  localparam logic [15:0] GN = 16'h0140;

  initial begin
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0 && dec_sample == 1'b0, "R1 reset outputs", int'(dec_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: enable clear after reset
    frame(0, 16'h0, 2, 8'h01, 1'b0, "R2 disabled at reset");

    // R3: reset defaults, only ctl fields written
    wr_ctl(1'b1, 2'd1, 2'd3);
    frame(1, EV, 1, 8'h01, 1'b1, "R3 v1 type B defaults to 1");
    frame(1, EV, 1, 8'h02, 1'b0, "R3 v1 type 2 unmatched by defaults");
    wr_ctl(1'b1, 2'd2, 2'd0);
    frame(0, 16'h0, 2, 8'h01, 1'b1, "R3 v2 type B defaults to 1");
    frame(0, 16'h0, 2, 8'h03, 1'b0, "R3 v2 type 3 unmatched by defaults");

    wr_types(8'h05, 8'h07, 4'h3, 4'h9);
    // R6 / R5 / R4 / R7 in mode 1
    wr_ctl(1'b1, 2'd1, 2'd1);
    frame(1, EV, 1, 8'h05, 1'b1, "R6 v1 matches type A");
    frame(1, EV, 1, 8'h07, 1'b1, "R6 v1 matches type B");
    frame(1, EV, 1, 8'h06, 1'b0, "R6 v1 matches neither");
    frame(1, GN, 1, 8'h05, 1'b0, "R5 general port not selected");
    frame(0, 16'h0, 1, 8'h05, 1'b0, "R4 ethernet PTP rejected in mode 1");
    frame(1, EV, 2, 8'h03, 1'b0, "R7 v2 rejected in mode 1");
    wr_ctl(1'b1, 2'd1, 2'd2);
    frame(1, GN, 1, 8'h05, 1'b1, "R5 general port selected");
    frame(1, EV, 1, 8'h05, 1'b0, "R5 event port not selected");
    wr_ctl(1'b1, 2'd1, 2'd0);
    frame(1, EV, 1, 8'h05, 1'b0, "R5 no port selected");

    // R6 wildcard
    wr_ctl(1'b1, 2'd1, 2'd3);
    wr_types(8'h05, 8'hFF, 4'h3, 4'h9);
    frame(1, EV, 1, 8'h42, 1'b1, "R6 v1 wildcard");
    wr_types(8'h05, 8'h07, 4'h3, 4'h9);

    // R10 boundary on v1 type byte (offset 62)
    build(1, EV, 1, 8'h07);
    send(63, 1'b1, "R10 UDP v1 ends on type byte", 1'b0);
    build(1, EV, 1, 8'h07);
    send(62, 1'b0, "R10 UDP v1 one byte short", 1'b0);

    // mode 2
    wr_ctl(1'b1, 2'd2, 2'd3);
    frame(1, EV, 1, 8'h05, 1'b0, "R6 v1 rejected outside mode 1");
    frame(1, GN, 2, 8'h03, 1'b1, "R9 v2 UDP matches type A");
    frame(1, EV, 2, 8'h09, 1'b1, "R9 v2 UDP matches type B");
    frame(1, EV, 2, 8'h04, 1'b0, "R9 v2 matches neither");
    frame(0, 16'h0, 2, 8'h09, 1'b1, "R4 ethernet PTP accepted in mode 2");
    build(0, 16'h0, 2, 8'h09);
    send(flen, 1'b1, "R4 ethernet PTP with stalls", 1'b1);
    build(0, 16'h0, 2, 8'h09);
    send(16, 1'b1, "R10 ethernet v2 ends on version byte", 1'b0);
    build(0, 16'h0, 2, 8'h09);
    send(15, 1'b0, "R10 ethernet v2 one byte short", 1'b0);
    frame(3, 16'h0, 2, 8'h09, 1'b0, "R10 other ethertype");
    frame(2, EV, 2, 8'h09, 1'b0, "R10 IPv4 non-UDP");
    frame(0, 16'h0, 3, 8'h09, 1'b0, "R10 unknown version");
    build(1, EV, 2, 8'h09);
    send(30, 1'b0, "R10 UDP frame cut in IP header", 1'b0);

    // mode 0
    wr_ctl(1'b1, 2'd0, 2'd3);
    frame(1, EV, 2, 8'h03, 1'b0, "R7 v2 over UDP rejected in mode 0");
    frame(0, 16'h0, 2, 8'h03, 1'b1, "R9 ethernet v2 accepted in mode 0");

    // mode 3
    wr_ctl(1'b1, 2'd3, 2'd1);
    frame(0, 16'h0, 2, 8'h07, 1'b1, "R8 type 7 below 8");
    frame(0, 16'h0, 2, 8'h08, 1'b0, "R8 type 8 not below 8");
    frame(1, EV, 2, 8'h00, 1'b1, "R8 UDP type 0");
    frame(1, EV, 1, 8'h05, 1'b0, "R8 v1 rejected in mode 3");

    // R9 v2 wildcard
    wr_ctl(1'b1, 2'd2, 2'd0);
    wr_types(8'h05, 8'h07, 4'hF, 4'h9);
    frame(0, 16'h0, 2, 8'h0C, 1'b1, "R9 v2 wildcard type A");

    // R2 disable again
    wr_ctl(1'b0, 2'd2, 2'd3);
    frame(0, 16'h0, 2, 8'h0C, 1'b0, "R2 disabled after use");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R1 every frame decided", exp_q.size(), 0);
    finish_run();
  end

endmodule